// File: doc/BRIEF.md
# Slave-Serial Converter Readout Controller

This block sits on the host side of a successive-approximation converter whose serial port runs from a clock that the host supplies. For each request it issues an active-low convert-start pulse and watches the converter's busy flag. It then opens a read window by pulling chip select and read low together. It clocks the result in most significant bit first and delivers it with a one-cycle valid pulse. A clock-source select output is held high, which keeps the converter in externally clocked mode.

A mode input picks when the read happens. In read-after mode the frame starts once busy has fallen, so the word is the conversion just taken. In read-during mode the frame starts as soon as busy rises, so the word is the result of the previous conversion. The serial clock is stopped whenever busy has been high for longer than half the nominal conversion time. A frame caught by that limit pauses and resumes after busy falls. A daisy-chain input stretches the frame to two words, which suits two converters that share one data line. The serial clock's idle level is a configuration input, and its rate is the system clock divided by an even parameter.

Top module: `sar_slave_reader`

## Requirements
- R1: After reset, cnvStN, csN and rdN are high, sclkOut sits at the idle level, resultValid is low and extClkSel is high.
- R2: A start request is taken only when the controller is idle and busyIn is low. cnvStN is then low for exactly CNV_PULSE cycles. A request made while busyIn is high produces no convert pulse.
- R3: With modeDuring = 0, csN and rdN stay high for the whole time busyIn is high. The frame begins after busyIn falls, and resultData holds the new conversion, first serial bit in bit 15.
- R4: With modeDuring = 1, the frame begins once busyIn rises, and resultData holds the result of the conversion before the one just started.
- R5: sclkOut keeps its level on any clock edge that follows a cycle in which busyIn has already been high for HALF_CONV or more cycles. A frame interrupted this way resumes after busyIn falls and returns the correct word.
- R6: While csN is high, sclkOut equals sclkIdleHigh. Each bit is captured on the clock's move away from idle, and the converter launches the next bit on the return to idle. Both idle levels give the correct result.
- R7: With daisyEn = 1, a frame is 32 bits. The first 16 bits go to resultData and the last 16 to resultAux. With daisyEn = 0, resultAux is zero.
- R8: resultValid is high for exactly one cycle per frame, csN is high in that cycle, and the result ports are valid during it.
- R9: A frame has exactly 16 leading clock edges, or 32 in daisy mode. When the frame is not paused, those edges are CLK_DIV system cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request a conversion and readout |
| modeDuring | input | 1 | 0: read after conversion, 1: read previous result during conversion |
| daisyEn | input | 1 | Read two chained 16-bit words in one frame |
| sclkIdleHigh | input | 1 | Idle level of the serial clock |
| busyIn | input | 1 | Converter busy flag |
| sdoIn | input | 1 | Converter serial data out |
| cnvStN | output | 1 | Active-low convert-start strobe |
| csN | output | 1 | Active-low chip select |
| rdN | output | 1 | Active-low read enable |
| sclkOut | output | 1 | Serial clock to the converter |
| extClkSel | output | 1 | Clock-source select, held high |
| resultData | output | 16 | First (or only) word of the frame |
| resultAux | output | 16 | Second word in daisy mode, else zero |
| resultValid | output | 1 | One-cycle pulse marking a new result |

## Verification
The hardest case to reach is a read-during frame that runs into the half-conversion limit. The serial clock has to freeze mid-word and pick up again after busy drops, and no bit may be lost or repeated. The bench's converter model holds busy for 40 cycles against a 20-cycle limit with a divide-by-4 clock. Sixteen bits then need 64 cycles, so the frame must stop after about five bits and finish later. The model snapshots its output word when the read window opens, even though a new conversion lands while the frame is paused. A correct previous-result word, together with a check that valid arrived after busy fell, therefore shows that the pause and resume really took place.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CNV,
    ST_WAIT_HI,
    ST_WAIT_LO,
    ST_SHIFT,
    ST_DONE
  } rdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clkRun;    // advance the serial clock divider this cycle
    logic frameClr;  // hold divider, phase and bit count at zero
    logic latch;     // copy the shift register to the result ports
  } ctlStrobe_t;

endpackage

// File: rtl/sar_rd_ctrl.sv
module sar_rd_ctrl
  import sar_rd_pkg::*;
#(
  parameter int CNV_PULSE = 2,
  parameter int HALF_CONV = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       modeDuring,
  input  logic       busyIn,
  input  logic       frameDone,
  output ctlStrobe_t strb,
  output logic       cnvStN,
  output logic       csN,
  output logic       rdN,
  output logic       resultValid
);

  localparam int CNV_W = $clog2(CNV_PULSE + 1);
  localparam int TMR_W = $clog2(HALF_CONV + 1);
  localparam logic [CNV_W-1:0] CNV_LAST = CNV_W'(CNV_PULSE - 1);
  localparam logic [TMR_W-1:0] TMR_MAX  = TMR_W'(HALF_CONV);

  rdState_t         state;
  logic             modeQ;
  logic [CNV_W-1:0] cnvCnt;
  logic [TMR_W-1:0] busyTmr;
  logic             lateBusy;

  // cycles busy has been high, saturating at the half-conversion mark
  assign lateBusy = busyIn && (busyTmr == TMR_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      modeQ   <= 1'b0;
      cnvCnt  <= '0;
      busyTmr <= '0;
    end else begin
      if (!busyIn) busyTmr <= '0;
      else if (busyTmr != TMR_MAX) busyTmr <= busyTmr + 1'b1;

      case (state)
        ST_IDLE: if (startReq && !busyIn) begin
          state  <= ST_CNV;
          modeQ  <= modeDuring;
          cnvCnt <= '0;
        end
        ST_CNV: begin
          cnvCnt <= cnvCnt + 1'b1;
          if (cnvCnt == CNV_LAST) state <= ST_WAIT_HI;
        end
        ST_WAIT_HI: if (busyIn) state <= modeQ ? ST_SHIFT : ST_WAIT_LO;
        ST_WAIT_LO: if (!busyIn) state <= ST_SHIFT;
        ST_SHIFT:   if (frameDone) state <= ST_DONE;
        ST_DONE:    state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cnvStN        = (state != ST_CNV);
    csN           = (state != ST_SHIFT);
    rdN           = (state != ST_SHIFT);
    resultValid   = (state == ST_DONE);
    strb.frameClr = (state != ST_SHIFT);
    strb.clkRun   = (state == ST_SHIFT) && (!busyIn || (modeQ && !lateBusy));
    strb.latch    = (state == ST_SHIFT) && frameDone;
  end

endmodule

// File: rtl/sar_rd_datapath.sv
module sar_rd_datapath
  import sar_rd_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic              daisyEn,
  input  logic              sclkIdleHigh,
  input  logic              sdoIn,
  output logic              sclkOut,
  output logic              frameDone,
  output logic [WORD_W-1:0] resultData,
  output logic [WORD_W-1:0] resultAux
);

  localparam int HALF_DIV = CLK_DIV / 2;
  localparam int DIV_W    = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int FRAME_W  = 2 * WORD_W;
  localparam int BIT_W    = $clog2(FRAME_W + 1);

  logic [DIV_W-1:0]   divCnt;
  logic               phase;
  logic [BIT_W-1:0]   bitCnt;
  logic [BIT_W-1:0]   totalBits;
  logic [FRAME_W-1:0] shReg;
  logic               leadStep;
  logic               lastStep;

  assign totalBits = daisyEn ? BIT_W'(FRAME_W) : BIT_W'(WORD_W);
  assign frameDone = (bitCnt == totalBits);
  assign leadStep  = (divCnt == DIV_W'(HALF_DIV - 1));
  assign lastStep  = (divCnt == DIV_W'(CLK_DIV - 1));
  assign sclkOut   = phase ^ sclkIdleHigh;

  // first half of each bit at idle level, second half away from idle;
  // capture on the move away from idle, converter launches on the return
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      phase  <= 1'b0;
      bitCnt <= '0;
      shReg  <= '0;
    end else if (strb.frameClr) begin
      divCnt <= '0;
      phase  <= 1'b0;
      bitCnt <= '0;
    end else if (strb.clkRun && !frameDone) begin
      divCnt <= lastStep ? '0 : divCnt + 1'b1;
      if (leadStep) begin
        phase <= 1'b1;
        shReg <= {shReg[FRAME_W-2:0], sdoIn};
      end
      if (lastStep) begin
        phase  <= 1'b0;
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultData <= '0;
      resultAux  <= '0;
    end else if (strb.latch) begin
      resultData <= daisyEn ? shReg[FRAME_W-1:WORD_W] : shReg[WORD_W-1:0];
      resultAux  <= daisyEn ? shReg[WORD_W-1:0] : '0;
    end
  end

endmodule

// File: rtl/sar_slave_reader.sv
module sar_slave_reader
  import sar_rd_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int CLK_DIV   = 4,
  parameter int CNV_PULSE = 2,
  parameter int HALF_CONV = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              modeDuring,
  input  logic              daisyEn,
  input  logic              sclkIdleHigh,
  input  logic              busyIn,
  input  logic              sdoIn,
  output logic              cnvStN,
  output logic              csN,
  output logic              rdN,
  output logic              sclkOut,
  output logic              extClkSel,
  output logic [WORD_W-1:0] resultData,
  output logic [WORD_W-1:0] resultAux,
  output logic              resultValid
);

  ctlStrobe_t strb;
  logic       frameDone;

  assign extClkSel = 1'b1;

  sar_rd_ctrl #(
    .CNV_PULSE(CNV_PULSE),
    .HALF_CONV(HALF_CONV)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .modeDuring (modeDuring),
    .busyIn     (busyIn),
    .frameDone  (frameDone),
    .strb       (strb),
    .cnvStN     (cnvStN),
    .csN        (csN),
    .rdN        (rdN),
    .resultValid(resultValid)
  );

  sar_rd_datapath #(
    .WORD_W (WORD_W),
    .CLK_DIV(CLK_DIV)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .daisyEn     (daisyEn),
    .sclkIdleHigh(sclkIdleHigh),
    .sdoIn       (sdoIn),
    .sclkOut     (sclkOut),
    .frameDone   (frameDone),
    .resultData  (resultData),
    .resultAux   (resultAux)
  );

endmodule

// File: rtl/sar_rd_checker.sv
module sar_rd_checker #(
  parameter int HALF_CONV = 20
) (
  input logic clk,
  input logic rstN,
  input logic busyIn,
  input logic sclkOut,
  input logic sclkIdleHigh,
  input logic csN,
  input logic cnvStN,
  input logic resultValid
);

  localparam int RUN_W = $clog2(HALF_CONV + 2);

  logic [RUN_W-1:0] busyRun;
  logic             pastHalf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else if (!busyIn) busyRun <= '0;
    else if (busyRun < RUN_W'(HALF_CONV)) busyRun <= busyRun + 1'b1;
  end

  assign pastHalf = busyIn && (busyRun >= RUN_W'(HALF_CONV));

  AST_LATE_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    pastHalf |=> $stable(sclkOut)); // R5

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (sclkOut == sclkIdleHigh)); // R6

  AST_NO_CNV_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cnvStN) |-> !$past(busyIn)); // R2

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid); // R8

  AST_VALID_CS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> csN); // R8

endmodule

bind sar_slave_reader sar_rd_checker #(.HALF_CONV(HALF_CONV)) u_sar_rd_checker (
  .clk         (clk),
  .rstN        (rstN),
  .busyIn      (busyIn),
  .sclkOut     (sclkOut),
  .sclkIdleHigh(sclkIdleHigh),
  .csN         (csN),
  .cnvStN      (cnvStN),
  .resultValid (resultValid)
);

// File: tb/sar_slave_reader_bench.sv
module sar_slave_reader_bench;

  localparam int CLK_DIV   = 4;
  localparam int CNV_PULSE = 2;
  localparam int HALF_CONV = 20;
  localparam int CONV_CYC  = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        modeDuring = 1'b0;
  logic        daisyEn = 1'b0;
  logic        sclkIdleHigh = 1'b0;
  logic        busyIn;
  logic        sdoIn;
  logic        cnvStN, csN, rdN, sclkOut, extClkSel, resultValid;
  logic [15:0] resultData, resultAux;

  always #10 clk = ~clk;

  sar_slave_reader #(
    .WORD_W(16), .CLK_DIV(CLK_DIV), .CNV_PULSE(CNV_PULSE), .HALF_CONV(HALF_CONV)
  ) u_sar_slave_reader (
    .clk(clk), .rstN(rstN), .startReq(startReq), .modeDuring(modeDuring),
    .daisyEn(daisyEn), .sclkIdleHigh(sclkIdleHigh), .busyIn(busyIn), .sdoIn(sdoIn),
    .cnvStN(cnvStN), .csN(csN), .rdN(rdN), .sclkOut(sclkOut), .extClkSel(extClkSel),
    .resultData(resultData), .resultAux(resultAux), .resultValid(resultValid)
  );

  int checks = 0;
  int errors = 0;

  // ---------------- converter model ----------------
  logic        busyM = 1'b0;
  logic        forceBusy = 1'b0;
  logic        cnvPrev = 1'b1;
  int          convLeft = 0;
  logic [15:0] devOut = 16'h0000, devOut2 = 16'h0000;
  logic [15:0] nextSample = 16'h0000, nextSample2 = 16'h0000;
  logic [31:0] shFrame = 32'h0;
  int          bitIdx = 0;
  logic        sclkSeen = 1'b0;

  assign busyIn = busyM | forceBusy;
  assign sdoIn  = (bitIdx < 32) ? shFrame[31 - bitIdx] : 1'b0;

  always @(posedge clk) begin
    cnvPrev <= cnvStN;
    if (!cnvPrev && cnvStN) begin
      busyM    <= 1'b1;
      convLeft <= CONV_CYC;
    end else if (convLeft > 1) begin
      convLeft <= convLeft - 1;
    end else if (convLeft == 1) begin
      convLeft <= 0;
      busyM    <= 1'b0;
      devOut   <= nextSample;
      devOut2  <= nextSample2;
    end
  end

  // output word is frozen when the read window opens; next bit launched on return to idle
  always @(negedge clk) begin
    if (csN || rdN) begin
      bitIdx  = 0;
      shFrame = {devOut, devOut2};
    end else if (sclkOut !== sclkSeen && sclkOut === sclkIdleHigh) begin
      bitIdx = bitIdx + 1;
    end
    sclkSeen = sclkOut;
  end

  // ---------------- monitors ----------------
  int   cyc = 0, cnvLowCnt = 0, leadEdges = 0, csBusyA = 0, lateToggles = 0;
  int   busyRun = 0, firstLead = -1, lastLead = -1;
  logic monSclk = 1'b0, prevLate = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!cnvStN) cnvLowCnt++;
    if (sclkOut !== monSclk && sclkOut !== sclkIdleHigh) begin
      leadEdges++;
      if (firstLead < 0) firstLead = cyc;
      lastLead = cyc;
    end
    if (!csN && busyIn && !modeDuring) csBusyA++;
    if (prevLate && sclkOut !== monSclk) lateToggles++;
    busyRun  = busyIn ? busyRun + 1 : 0;
    prevLate = busyIn && (busyRun > HALF_CONV);
    monSclk  = sclkOut;
  end

  // ---------------- helpers ----------------
  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearMon();
    cnvLowCnt = 0; leadEdges = 0; csBusyA = 0; lateToggles = 0;
    firstLead = -1; lastLead = -1;
  endtask

  task automatic doFrame(input bit mode, input bit daisy, output bit got,
                         output logic [15:0] d, output logic [15:0] a,
                         output bit csV, output bit busyV, output bit validNext);
    modeDuring = mode;
    daisyEn    = daisy;
    clearMon();
    startReq = 1'b1;
    tick();
    startReq = 1'b0;
    got = 1'b0; d = '0; a = '0; csV = 1'b0; busyV = 1'b0; validNext = 1'b0;
    for (int i = 0; i < 3000 && !got; i++) begin
      if (resultValid) begin
        got = 1'b1; d = resultData; a = resultAux; csV = csN; busyV = busyIn;
      end else begin
        tick();
      end
    end
    tick();
    validNext = resultValid;
    while (busyIn) tick();
    repeat (3) tick();
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    repeat (3) tick();
    chk("R1", "cnvStN", cnvStN, 1'b1);
    chk("R1", "csN", csN, 1'b1);
    chk("R1", "rdN", rdN, 1'b1);
    chk("R1", "sclkOut idle", sclkOut, 1'b0);
    chk("R1", "resultValid", resultValid, 1'b0);
    chk("R1", "extClkSel", extClkSel, 1'b1);
    rstN = 1'b1;
    repeat (2) tick();
  endtask

  task automatic testBusyBlocks();
    forceBusy = 1'b1;
    tick();
    clearMon();
    startReq = 1'b1;
    tick();
    startReq = 1'b0;
    repeat (10) tick();
    chk("R2", "convert pulses while busy", cnvLowCnt, 0);
    chk("R2", "csN while busy", csN, 1'b1);
    forceBusy = 1'b0;
    repeat (2) tick();
  endtask

  task automatic testReadAfter();
    bit got, csV, busyV, vn;
    logic [15:0] d, a;
    nextSample = 16'hA5C3;
    doFrame(1'b0, 1'b0, got, d, a, csV, busyV, vn);
    chk("R3", "valid seen", got, 1'b1);
    chk("R2", "convert pulse width", cnvLowCnt, CNV_PULSE);
    chk("R3", "result after convert", d, 16'hA5C3);
    chk("R3", "csN low during busy", csBusyA, 0);
    chk("R7", "aux zero without daisy", a, 16'h0000);
    chk("R8", "csN high with valid", csV, 1'b1);
    chk("R8", "valid lasts one cycle", vn, 1'b0);
    chk("R9", "leading edges", leadEdges, 16);
    chk("R9", "edge spacing", lastLead - firstLead, 15 * CLK_DIV);
  endtask

  task automatic testReadDuring();
    bit got, csV, busyV, vn;
    logic [15:0] d, a;
    nextSample = 16'h1234;
    doFrame(1'b1, 1'b0, got, d, a, csV, busyV, vn);
    chk("R4", "valid seen", got, 1'b1);
    chk("R4", "previous result", d, 16'hA5C3);
    chk("R5", "toggles late in busy", lateToggles, 0);
    chk("R5", "frame paused until busy low", busyV, 1'b0);
    chk("R9", "leading edges paused frame", leadEdges, 16);
    chk("R8", "valid lasts one cycle", vn, 1'b0);
  endtask

  task automatic testIdleHigh();
    bit got, csV, busyV, vn;
    logic [15:0] d, a;
    sclkIdleHigh = 1'b1;
    repeat (2) tick();
    chk("R6", "idle level high", sclkOut, 1'b1);
    nextSample = 16'h8001;
    doFrame(1'b0, 1'b0, got, d, a, csV, busyV, vn);
    chk("R6", "result with high idle", d, 16'h8001);
    chk("R6", "idle level after frame", sclkOut, 1'b1);
    chk("R9", "leading edges high idle", leadEdges, 16);
    sclkIdleHigh = 1'b0;
    repeat (2) tick();
  endtask

  task automatic testDaisy();
    bit got, csV, busyV, vn;
    logic [15:0] d, a;
    nextSample  = 16'hBEEF;
    nextSample2 = 16'h0F0F;
    doFrame(1'b0, 1'b1, got, d, a, csV, busyV, vn);
    chk("R7", "first device word", d, 16'hBEEF);
    chk("R7", "second device word", a, 16'h0F0F);
    chk("R7", "leading edges daisy", leadEdges, 32);
    chk("R9", "edge spacing daisy", lastLead - firstLead, 31 * CLK_DIV);
  endtask

  initial begin
    testReset();
    testBusyBlocks();
    testReadAfter();
    testReadDuring();
    testIdleHigh();
    testDaisy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule